// File: doc/BRIEF.md
# Spreading-Code Replica Generator with Half-Chip Tap Spacing

This block makes the local copy of a 1023-chip spreading code for one correlator channel, together with two delayed copies. A phase accumulator runs on the system clock and adds a programmable increment word on every cycle. Each time the accumulator's top bit changes, a half-chip event occurs. Every second half-chip event is a chip event, which is the same as an accumulator wraparound. Chip events step a pair of 10-stage maximal-length shift registers whose outputs, combined, form a Gold code. Half-chip events shift that code through a two-stage register. The result is three replicas spaced half a chip apart.

A tracking loop outside this block writes the increment word to steer the code rate and phase. The correlator takes the three replicas and the epoch strobe. The strobe marks the first chip of each code period. Two tap-select inputs choose which second-register stages feed the output, and that choice sets which code is produced.

Top module: `code_nco_epl`

## Requirements
- R1: A write on `inc_wr_i` stores `inc_data_i` at that clock edge. The accumulator adds the stored word at every later edge, so a new rate applies from the next clock on. Written words must be below half the accumulator range.
- R2: A half-chip event belongs to a clock edge at which the accumulator's top bit differs before and after the addition. On the edge that follows that event, `prompt_o` loads `early_o` and `late_o` loads the old `prompt_o`.
- R3: Every second half-chip event since reset is a chip event. This is the edge on which the accumulator wraps. The code generator advances one chip on the edge that follows a chip event.
- R4: Register A uses feedback from stages 3 and 10. Register B uses feedback from stages 2, 3, 6, 8, 9 and 10. In both registers the feedback enters stage 1 and stage k moves to stage k+1. `early_o` is A's stage 10 XOR B's stage `tap_a_i` XOR B's stage `tap_b_i`, where stages are numbered 1 to 10.
- R5: A synchronous active-high `rst_i` sets both registers to all ones. It clears the accumulator, the stored increment, the pending events, `prompt_o`, `late_o` and `epoch_o`. `early_o` then reads 1.
- R6: With tap selects 2 and 6, the first ten chips after reset are 1,1,0,0,1,0,0,0,0,0.
- R7: `epoch_o` is a one-cycle pulse. It is high in the cycle in which the generator has just returned to its reset state, which happens once every 1023 chips.
- R8: `prompt_o` is `early_o` delayed by one half-chip event, and `late_o` is `prompt_o` delayed by one more. Neither output changes on an edge without a half-chip event.
- R9: With a stored increment of zero, no further events occur and all four outputs stay constant.
- R10: A change on the tap selects reaches `early_o` in the same cycle, without waiting for a chip event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| inc_wr_i | input | 1 | Load strobe for the increment word |
| inc_data_i | input | ACC_W | New code-phase increment per clock |
| tap_a_i | input | SEL_W | First register-B stage used for the output (1..10) |
| tap_b_i | input | SEL_W | Second register-B stage used for the output (1..10) |
| early_o | output | 1 | Generator output, the earliest replica |
| prompt_o | output | 1 | Replica half a chip behind early |
| late_o | output | 1 | Replica a full chip behind early |
| epoch_o | output | 1 | One-cycle strobe at the first chip of each period |

## Verification
The assertions assume that every written increment is below half the accumulator range. Under that condition the top bit flips at most once per clock, and chip events can never fall on consecutive cycles. They also assume that the two tap selects are distinct and lie between 1 and 10 whenever reset is low. The bench sets legal taps before it releases reset. Its largest increment is 127 on an 8-bit accumulator, one below the limit. Every tap change picks another distinct in-range pair.

// File: rtl/code_nco_pkg.sv
package code_nco_pkg;

    // Number of stages in each code shift register
    localparam int CODE_STAGES = 10;

    // Feedback masks, stage k at bit k-1
    localparam logic [CODE_STAGES-1:0] REG_A_FB = 10'h204; // stages 3, 10
    localparam logic [CODE_STAGES-1:0] REG_B_FB = 10'h3A6; // stages 2,3,6,8,9,10

    // Width of a tap-select value able to name stages 1..CODE_STAGES
    localparam int TAP_SEL_W = $clog2(CODE_STAGES + 1);

    // Number of half-chip delay stages after the generator
    localparam int DELAY_STAGES = 2;

endpackage

// File: rtl/code_phase_acc.sv
module code_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_wr_i,
    input  logic [ACC_W-1:0] inc_data_i,
    output logic             half_o,
    output logic             chip_o
);
    localparam int TOP = ACC_W - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] inc;
        logic             half;
        logic             odd;
        logic             chip;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic             flip;

    always_comb begin
        sum        = st_q.acc + st_q.inc;
        flip       = sum[TOP] ^ st_q.acc[TOP];
        st_d       = st_q;
        st_d.acc   = sum;
        st_d.half  = flip;
        st_d.odd   = st_q.odd ^ flip;
        st_d.chip  = flip & st_q.odd;
        if (inc_wr_i) begin
            st_d.inc = inc_data_i;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign half_o = st_q.half;
    assign chip_o = st_q.chip;

    // R1: the stored increment stays below half range
    a_r1_inc_below_half: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.inc[TOP] == 1'b0);

    // R3: chip events never arrive on back-to-back cycles
    a_r3_chip_spaced: assert property (@(posedge clk_i) disable iff (rst_i)
        chip_o |=> !chip_o);

    // R3: a chip event always follows a cycle with no chip event and marks a wrap
    a_r3_chip_wraps: assert property (@(posedge clk_i) disable iff (rst_i)
        chip_o |-> (st_q.acc < st_q.inc) || (st_q.inc == '0 && st_q.acc == '0) || (st_q.acc < $past(st_q.acc)));

endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen
    import code_nco_pkg::*;
#(
    parameter int                    LEN   = CODE_STAGES,
    parameter logic [LEN-1:0]        FB_A  = REG_A_FB,
    parameter logic [LEN-1:0]        FB_B  = REG_B_FB,
    parameter int                    SEL_W = TAP_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] tap_a_i,
    input  logic [SEL_W-1:0] tap_b_i,
    output logic             chip_o,
    output logic             epoch_o
);
    typedef struct packed {
        logic [LEN-1:0] reg_a;
        logic [LEN-1:0] reg_b;
        logic           epoch;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [LEN-1:0] step_a, step_b;

    function automatic logic pick_stage(input logic [LEN-1:0] r, input logic [SEL_W-1:0] s);
        logic b;
        b = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            if (s == SEL_W'(k + 1)) begin
                b = r[k];
            end
        end
        return b;
    endfunction

    always_comb begin
        step_a     = {st_q.reg_a[LEN-2:0], ^(st_q.reg_a & FB_A)};
        step_b     = {st_q.reg_b[LEN-2:0], ^(st_q.reg_b & FB_B)};
        st_d       = st_q;
        st_d.epoch = 1'b0;
        if (adv_i) begin
            st_d.reg_a = step_a;
            st_d.reg_b = step_b;
            st_d.epoch = (step_a == '1);
        end
        if (rst_i) begin
            st_d.reg_a = '1;
            st_d.reg_b = '1;
            st_d.epoch = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign chip_o  = st_q.reg_a[LEN-1] ^ pick_stage(st_q.reg_b, tap_a_i)
                                       ^ pick_stage(st_q.reg_b, tap_b_i);
    assign epoch_o = st_q.epoch;

    // R4: neither register ever falls into the all-zero lockup state
    a_r4_regs_live: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.reg_a != '0) && (st_q.reg_b != '0));

    // R7: the epoch strobe lasts a single cycle
    a_r7_epoch_single: assert property (@(posedge clk_i) disable iff (rst_i)
        epoch_o |=> !epoch_o);

    // R7: at an epoch the second register has also returned to its start
    a_r7_epoch_b_start: assert property (@(posedge clk_i) disable iff (rst_i)
        epoch_o |-> (st_q.reg_b == '1));

    // R3: the code state holds while no chip event is present
    a_r3_hold_between: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(st_q.reg_a));

endmodule

// File: rtl/half_chip_delay.sv
module half_chip_delay
    import code_nco_pkg::*;
#(
    parameter int STAGES = DELAY_STAGES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              shift_i,
    input  logic              code_i,
    output logic [STAGES-1:0] taps_o
);
    typedef struct packed {
        logic [STAGES-1:0] line;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.line[0] = code_i;
            for (int k = 1; k < STAGES; k++) begin
                st_d.line[k] = st_q.line[k-1];
            end
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign taps_o = st_q.line;

    // R8: the delay line moves only on half-chip events
    a_r8_hold_no_event: assert property (@(posedge clk_i) disable iff (rst_i)
        !shift_i |=> $stable(taps_o));

    // R8: on an event each stage takes the previous value of the one before it
    a_r8_stage_follow: assert property (@(posedge clk_i) disable iff (rst_i)
        shift_i |=> (taps_o[STAGES-1] == $past(taps_o[STAGES-2])) && (taps_o[0] == $past(code_i)));

endmodule

// File: rtl/code_nco_epl.sv
module code_nco_epl
    import code_nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int SEL_W = TAP_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_wr_i,
    input  logic [ACC_W-1:0] inc_data_i,
    input  logic [SEL_W-1:0] tap_a_i,
    input  logic [SEL_W-1:0] tap_b_i,
    output logic             early_o,
    output logic             prompt_o,
    output logic             late_o,
    output logic             epoch_o
);
    localparam int NDLY = DELAY_STAGES;

    logic            half_ev, chip_ev;
    logic [NDLY-1:0] dly_taps;

    code_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .inc_wr_i   (inc_wr_i),
        .inc_data_i (inc_data_i),
        .half_o     (half_ev),
        .chip_o     (chip_ev)
    );

    gold_code_gen #(
        .LEN   (CODE_STAGES),
        .FB_A  (REG_A_FB),
        .FB_B  (REG_B_FB),
        .SEL_W (SEL_W)
    ) u_gen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (chip_ev),
        .tap_a_i (tap_a_i),
        .tap_b_i (tap_b_i),
        .chip_o  (early_o),
        .epoch_o (epoch_o)
    );

    half_chip_delay #(.STAGES(NDLY)) u_dly (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (half_ev),
        .code_i  (early_o),
        .taps_o  (dly_taps)
    );

    assign prompt_o = dly_taps[0];
    assign late_o   = dly_taps[NDLY-1];

    // R1: written increments stay below half the accumulator range
    a_r1_write_range: assert property (@(posedge clk_i) disable iff (rst_i)
        inc_wr_i |-> (inc_data_i[ACC_W-1] == 1'b0));

    // R4: tap selects are distinct and name real stages
    a_r4_taps_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        (tap_a_i != tap_b_i) && (tap_a_i >= SEL_W'(1)) && (tap_a_i <= SEL_W'(CODE_STAGES))
        && (tap_b_i >= SEL_W'(1)) && (tap_b_i <= SEL_W'(CODE_STAGES)));

    // R3/R2: a chip event always coincides with a half-chip event
    a_r3_chip_is_half: assert property (@(posedge clk_i) disable iff (rst_i)
        chip_ev |-> half_ev);

endmodule

// File: tb/code_nco_epl_test.sv
module code_nco_epl_test;
    localparam int W   = 8;
    localparam int LEN = 10;
    localparam int SW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr  = 1'b0;
    logic [W-1:0]  data = '0;
    logic [SW-1:0] ta = 4'd2;
    logic [SW-1:0] tb = 4'd6;
    logic          early, prompt, late, epoch;

    code_nco_epl #(.ACC_W(W), .SEL_W(SW)) uut (
        .clk_i(clk), .rst_i(rst), .inc_wr_i(wr), .inc_data_i(data),
        .tap_a_i(ta), .tap_b_i(tb),
        .early_o(early), .prompt_o(prompt), .late_o(late), .epoch_o(epoch)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0;

    // Bench model state built from the requirements
    logic [W-1:0]   m_acc, m_inc;
    logic           m_half, m_odd, m_chip, m_epoch, m_p, m_l;
    logic [LEN-1:0] m_a, m_b;
    int             m_chips;
    int             cyc = 0, ep_last = -1, ep_gap = -1;
    logic [9:0]     prn;

    function automatic logic stg(input logic [LEN-1:0] r, input int k);
        return (k >= 1 && k <= LEN) ? r[k-1] : 1'b0;
    endfunction

    function automatic logic m_early();
        return stg(m_a, 10) ^ stg(m_b, int'(ta)) ^ stg(m_b, int'(tb));
    endfunction

    task automatic model_edge();
        logic [W-1:0]   sum;
        logic           hd, e;
        logic [LEN-1:0] na, nb;
        if (rst) begin
            m_acc = '0; m_inc = '0; m_half = 0; m_odd = 0; m_chip = 0;
            m_epoch = 0; m_p = 0; m_l = 0; m_a = '1; m_b = '1; m_chips = 0;
        end else begin
            e   = m_early();
            sum = m_acc + m_inc;
            hd  = sum[W-1] != m_acc[W-1];
            if (m_half) begin
                m_l = m_p;
                m_p = e;
            end
            m_epoch = 1'b0;
            if (m_chip) begin
                na = {m_a[8:0], stg(m_a, 3) ^ stg(m_a, 10)};
                nb = {m_b[8:0], stg(m_b, 2) ^ stg(m_b, 3) ^ stg(m_b, 6)
                               ^ stg(m_b, 8) ^ stg(m_b, 9) ^ stg(m_b, 10)};
                m_a = na; m_b = nb; m_chips++;
                m_epoch = (na == '1);
            end
            m_chip = hd & m_odd;
            m_odd  = m_odd ^ hd;
            m_half = hd;
            m_acc  = sum;
            if (wr) m_inc = data;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        check("R3 R4 R10 early", {31'd0, early}, {31'd0, m_early()});
        check("R1 R2 R8 prompt/late", {30'd0, prompt, late}, {30'd0, m_p, m_l});
        check("R7 epoch", {31'd0, epoch}, {31'd0, m_epoch});
        if (!rst && m_chips < 10) prn[9 - m_chips] = early;
        if (epoch) begin
            if (ep_last >= 0) ep_gap = cyc - ep_last;
            ep_last = cyc;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_inc(input logic [W-1:0] v);
        wr = 1'b1; data = v;
        tick();
        wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] snap;
        run(3);
        // R5: reset state
        check("R5 reset outputs", {28'd0, early, prompt, late, epoch}, 32'b1000);
        rst = 1'b0;
        write_inc(8'd64);
        ep_last = -1; ep_gap = -1;
        run(8300);
        // R6: first ten chips for taps 2 and 6
        check("R6 first chips", {22'd0, prn}, {22'd0, 10'b1100100000});
        // R7: epochs 1023 chips apart, four clocks per chip
        check("R7 epoch spacing", ep_gap, 32'd4092);

        ta = 4'd3; tb = 4'd7;
        write_inc(8'd37);
        run(3000);
        ta = 4'd1; tb = 4'd10;
        write_inc(8'd127);
        run(3000);
        write_inc(8'd1);
        run(600);

        // R9: zero increment freezes the outputs
        write_inc(8'd0);
        run(4);
        snap = {early, prompt, late, epoch};
        for (int i = 0; i < 40; i++) begin
            tick();
            check("R9 frozen outputs", {28'd0, early, prompt, late, epoch}, {28'd0, snap});
        end

        // R10: tap change reaches early in the same cycle
        ta = 4'd5; tb = 4'd9;
        #1;
        check("R10 tap change", {31'd0, early}, {31'd0, m_early()});
        run(5);

        // R5: reset from a running state
        write_inc(8'd50);
        run(200);
        rst = 1'b1;
        run(2);
        check("R5 mid-run reset", {28'd0, early, prompt, late, epoch},
              {28'd0, m_early(), 3'b000});
        rst = 1'b0;
        write_inc(8'd90);
        run(500);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule